// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block collects level-sensitive interrupt requests from a set of sources and forwards them to the harts of a multi-CPU system. Each source has a small priority value. Each hart context has an enable bitmap and a priority threshold. A context's interrupt line rises when at least one source is pending, enabled for that context, and ranked above the threshold.

Software talks to the block over a single-cycle 32-bit register port. Read data is combinational in the cycle of the request, and writes and read side effects take effect at the closing clock edge. A handler reads its context's claim register to learn which source to serve. That read also takes the source out of the pending set, so no other hart serves it twice. Writing the same ID back to that register releases the source, and it can then be latched again.

Contexts are numbered so that CPU c owns context 2c+1. Even context numbers decode to nothing.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, enable bit, threshold and pending bit is zero, all interrupt outputs are low, and a claim read returns 0.
- R2: The priority of source ID sits at byte address 4*ID and keeps only the low PRIO_W bits; the upper read bits are 0. ID 0 reads as 0 and ignores writes.
- R3: Pending state reads at 0x1000 + 4*w, with source N at bit N%32 of word w = N/32. A source seen high while not claimed becomes pending at the next clock edge, and bit 0 of word 0 is always 0.
- R4: The enable bitmap of CPU c sits at 0x2000 + 0x80*(2c+1) + 4*w, with the same bit packing as the pending words. Enable bit 0 always reads 0. Even contexts and contexts beyond the CPU count read 0 and ignore writes.
- R5: The threshold of CPU c sits at 0x200000 + 0x1000*(2c+1) and keeps only the low PRIO_W bits.
- R6: irq_o[c] is high exactly when some source is pending, enabled for CPU c, and has a priority strictly greater than CPU c's threshold, so priority 0 never interrupts.
- R7: A read of 0x200004 + 0x1000*(2c+1) returns the qualifying source with the highest priority, choosing the lowest ID on a tie. It returns 0 when no source qualifies.
- R8: A claim read that returns a nonzero ID clears that source's pending bit at the same edge. The source is not latched as pending again while it stays claimed, even if its request input stays high.
- R9: Writing a claimed source ID to the claim register of a CPU that has it enabled releases it, and a still-high request is latched again. A write of an ID that is unclaimed, out of range, or not enabled for that CPU has no effect.
- R10: Misaligned addresses and addresses outside every register read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level request per source; bit 0 is unused |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_o | output | NUM_CPU | Interrupt line per CPU (context 2c+1) |

## Verification
The bench builds the block with 40 sources and 4 CPUs. With 40 sources the packing spills into a second pending and enable word, and that word is only partly populated, so the bits above source 39 must read zero. With 4 CPUs the highest context, 7, and the even context between two real ones both fall inside the decoded range. The claim scenarios cover equal-priority ties, priorities below the threshold, and completes on a CPU that has the source disabled.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
   localparam logic [31:0] ENA_BASE   = 32'h0000_2000;
   localparam logic [31:0] ENA_STRIDE = 32'h0000_0080;
   localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
   localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PRIO,
      RG_PEND,
      RG_ENA,
      RG_THR,
      RG_CLAIM
   } region_e;

   typedef struct packed {
      region_e     region;
      logic [15:0] index;   // source ID or bitmap word
      logic [15:0] slot;    // CPU number
   } decode_t;

endpackage

// File: rtl/pic_decode.sv
module pic_decode
   import pic_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 24
)(
   input  logic [ADDR_W-1:0] addr_i,
   output decode_t           dec_o
);
   localparam int NWORDS = (NUM_SRC + 31) / 32;

   logic [31:0] a;
   logic [31:0] off;
   logic [31:0] ctx;
   logic [31:0] word;

   always_comb begin
      a     = 32'(addr_i);
      off   = '0;
      ctx   = '0;
      word  = '0;
      dec_o = '{region: RG_NONE, index: '0, slot: '0};
      if (a[1:0] == 2'b00) begin
         if (a < PEND_BASE) begin
            word = {2'b00, a[31:2]};
            if (word != 0 && word < 32'(NUM_SRC)) begin
               dec_o.region = RG_PRIO;
               dec_o.index  = word[15:0];
            end
         end else if (a < ENA_BASE) begin
            word = {2'b00, a[31:2]} - 32'h400;
            if (word < 32'(NWORDS)) begin
               dec_o.region = RG_PEND;
               dec_o.index  = word[15:0];
            end
         end else if (a < CTX_BASE) begin
            off  = a - ENA_BASE;
            ctx  = off >> 7;
            word = {27'd0, off[6:2]};
            if (ctx[0] && (ctx >> 1) < 32'(NUM_CPU) && word < 32'(NWORDS)) begin
               dec_o.region = RG_ENA;
               dec_o.index  = word[15:0];
               dec_o.slot   = 16'(ctx >> 1);
            end
         end else begin
            off = a - CTX_BASE;
            ctx = off >> 12;
            if (ctx[0] && (ctx >> 1) < 32'(NUM_CPU)) begin
               dec_o.slot = 16'(ctx >> 1);
               if (off[11:0] == 12'h000)      dec_o.region = RG_THR;
               else if (off[11:0] == 12'h004) dec_o.region = RG_CLAIM;
            end
         end
      end
   end
endmodule

// File: rtl/pic_gateway.sv
module pic_gateway #(
   parameter int NUM_SRC = 40,
   parameter int IDW     = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               claim_v,
   input  logic [IDW-1:0]     claim_id,
   input  logic               done_v,
   input  logic [IDW-1:0]     done_id,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] busy_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_o <= '0;
         busy_o <= '0;
      end else begin
         pend_o[0] <= 1'b0;
         busy_o[0] <= 1'b0;
         for (int n = 1; n < NUM_SRC; n++) begin
            if (claim_v && claim_id == IDW'(n)) begin
               pend_o[n] <= 1'b0;
               busy_o[n] <= 1'b1;
            end else if (done_v && done_id == IDW'(n) && busy_o[n]) begin
               busy_o[n] <= 1'b0;
            end else if (src_i[n] && !busy_o[n]) begin
               pend_o[n] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int NUM_SRC = 40,
   parameter int PRIO_W  = 3,
   parameter int IDW     = 6
)(
   input  logic [NUM_SRC-1:0]             pend_i,
   input  logic [NUM_SRC-1:0]             ena_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]              thr_i,
   output logic [IDW-1:0]                 id_o,
   output logic                           irq_o
);
   logic [PRIO_W-1:0] best;

   // ascending scan with strict compare keeps the lowest ID on ties
   always_comb begin
      best = thr_i;
      id_o = '0;
      for (int n = 1; n < NUM_SRC; n++) begin
         if (pend_i[n] && ena_i[n] && prio_i[n] > best) begin
            best = prio_i[n];
            id_o = IDW'(n);
         end
      end
      irq_o = (id_o != '0);
   end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import pic_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int NUM_CPU = 4,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 24
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CPU-1:0] irq_o
);
   localparam int IDW = $clog2(NUM_SRC);
   localparam int CW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_src
      $error("irq_hub: NUM_SRC must be 2..1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 64) begin : g_bad_cpu
      $error("irq_hub: NUM_CPU must be 1..64");
   end
   if (PRIO_W < 1 || PRIO_W > 31) begin : g_bad_prio
      $error("irq_hub: PRIO_W must be 1..31");
   end
   if (ADDR_W < 22 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_hub: ADDR_W must be 22..32");
   end

   decode_t dec;
   logic    wr, rd;
   logic [IDW-1:0] src_sel;
   logic [CW-1:0]  cpu_sel;

   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] ena_q;
   logic [NUM_CPU-1:0][PRIO_W-1:0]  thr_q;
   logic [NUM_SRC-1:0] pend_q, busy_q;
   logic [NUM_CPU-1:0][IDW-1:0] arb_id;

   logic           claim_v, done_v;
   logic [IDW-1:0] claim_id, done_id;

   pic_decode #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
      .addr_i(bus_addr),
      .dec_o (dec)
   );

   assign wr      = bus_req &&  bus_we;
   assign rd      = bus_req && !bus_we;
   assign src_sel = dec.index[IDW-1:0];
   assign cpu_sel = dec.slot[CW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= '0;
         ena_q  <= '0;
         thr_q  <= '0;
      end else if (wr) begin
         case (dec.region)
            RG_PRIO: prio_q[src_sel] <= bus_wdata[PRIO_W-1:0];
            RG_THR:  thr_q[cpu_sel]  <= bus_wdata[PRIO_W-1:0];
            RG_ENA: begin
               for (int n = 1; n < NUM_SRC; n++) begin
                  if ((n / 32) == int'(dec.index))
                     ena_q[cpu_sel][n] <= bus_wdata[n % 32];
               end
            end
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_ctx
      pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
         .pend_i(pend_q),
         .ena_i (ena_q[c]),
         .prio_i(prio_q),
         .thr_i (thr_q[c]),
         .id_o  (arb_id[c]),
         .irq_o (irq_o[c])
      );
   end

   assign claim_id = arb_id[cpu_sel];
   assign claim_v  = rd && dec.region == RG_CLAIM && claim_id != '0;
   assign done_id  = bus_wdata[IDW-1:0];
   assign done_v   = wr && dec.region == RG_CLAIM && bus_wdata != 32'd0
                     && bus_wdata < 32'(NUM_SRC) && ena_q[cpu_sel][done_id];

   pic_gateway #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_gw (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i),
      .claim_v (claim_v),
      .claim_id(claim_id),
      .done_v  (done_v),
      .done_id (done_id),
      .pend_o  (pend_q),
      .busy_o  (busy_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (dec.region)
            RG_PRIO: bus_rdata[PRIO_W-1:0] = prio_q[src_sel];
            RG_THR:  bus_rdata[PRIO_W-1:0] = thr_q[cpu_sel];
            RG_CLAIM: bus_rdata[IDW-1:0]   = claim_id;
            RG_PEND: begin
               for (int n = 0; n < NUM_SRC; n++)
                  if ((n / 32) == int'(dec.index)) bus_rdata[n % 32] = pend_q[n];
            end
            RG_ENA: begin
               for (int n = 0; n < NUM_SRC; n++)
                  if ((n / 32) == int'(dec.index)) bus_rdata[n % 32] = ena_q[cpu_sel][n];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
   parameter int NUM_SRC = 40,
   parameter int NUM_CPU = 4,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 24
)(
   input logic               clk,
   input logic               rst_n,
   input logic               bus_req,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_rdata,
   input logic [NUM_CPU-1:0] irq_o,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] busy_q
);
   localparam int IDW = $clog2(NUM_SRC);
   localparam logic [31:0] CTX_END = 32'h0020_0000 + 32'h1000 * 32'(2 * NUM_CPU);

   logic [31:0] a;
   logic        rd, claim_rd;
   assign a        = 32'(bus_addr);
   assign rd       = bus_req && !bus_we;
   assign claim_rd = rd && a >= 32'h0020_0000 && a[11:0] == 12'h004;

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_o == '0);

   // R2
   prio_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && a < 32'h1000 |-> bus_rdata[31:PRIO_W] == '0);

   // R3
   reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[0]);

   // R6
   no_stray_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o != '0 |-> pend_q != '0);

   // R7
   claim_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_rd && bus_rdata != 0 |-> pend_q[bus_rdata[IDW-1:0]]);

   // R8
   claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_rd && bus_rdata != 0 |=> busy_q[$past(bus_rdata[IDW-1:0])]
                                     && !pend_q[$past(bus_rdata[IDW-1:0])]);

   // R8
   pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & busy_q) == '0);

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && (a[1:0] != 2'b00 || a >= CTX_END) |-> bus_rdata == '0);
endmodule

bind irq_hub irq_hub_chk #(
   .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .irq_o    (irq_o),
   .pend_q   (pend_q),
   .busy_q   (busy_q)
);

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
   localparam int NUM_SRC = 40;
   localparam int NUM_CPU = 4;
   localparam int PRIO_W  = 3;
   localparam int ADDR_W  = 24;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] src_i = '0;
   logic               bus_req = 1'b0;
   logic               bus_we = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic [NUM_CPU-1:0] irq_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   irq_hub #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [31:0] a_prio(int id);   return 32'(4 * id); endfunction
   function automatic logic [31:0] a_pend(int w);    return 32'h1000 + 32'(4 * w); endfunction
   function automatic logic [31:0] a_ena(int c, int w);
      return 32'h2000 + 32'h80 * 32'(2 * c + 1) + 32'(4 * w);
   endfunction
   function automatic logic [31:0] a_thr(int c);     return 32'h20_0000 + 32'h1000 * 32'(2 * c + 1); endfunction
   function automatic logic [31:0] a_clm(int c);     return a_thr(c) + 32'd4; endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] addr, logic [31:0] data);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr[ADDR_W-1:0]; bus_wdata = data;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [31:0] addr, output logic [31:0] data);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = addr[ADDR_W-1:0];
      #1 data = bus_rdata;
      @(posedge clk); #1;
      bus_req = 1'b0;
   endtask

   task automatic pulse(int n);
      @(negedge clk); src_i[n] = 1'b1;
      @(negedge clk); src_i[n] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      @(negedge clk);
      chk("R1 irq after reset", 32'(irq_o), 32'h0);
      rd(a_prio(5), d);    chk("R1 prio reset", d, 0);
      rd(a_ena(0, 0), d);  chk("R1 enable reset", d, 0);
      rd(a_thr(3), d);     chk("R1 threshold reset", d, 0);
      rd(a_pend(0), d);    chk("R1 pending reset", d, 0);
      rd(a_clm(0), d);     chk("R1 claim empty", d, 0);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(a_prio(5), 32'hFFFF_FFFD); rd(a_prio(5), d);  chk("R2 low bits kept", d, 5);
      wr(a_prio(0), 7);             rd(a_prio(0), d);  chk("R2 id0 reads zero", d, 0);
      wr(a_prio(39), 3);            rd(a_prio(39), d); chk("R2 last source", d, 3);
   endtask

   task automatic t_pending();
      logic [31:0] d;
      @(negedge clk); src_i[3] = 1'b1; src_i[35] = 1'b1; src_i[0] = 1'b1;
      @(negedge clk); src_i = '0;
      rd(a_pend(0), d); chk("R3 word0 packing", d, 32'h8);
      rd(a_pend(1), d); chk("R3 word1 packing", d, 32'h8);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(a_ena(1, 0), 32'hFFFF_FFFF); rd(a_ena(1, 0), d); chk("R4 bit0 forced low", d, 32'hFFFF_FFFE);
      wr(a_ena(1, 1), 32'hFFFF_FFFF); rd(a_ena(1, 1), d); chk("R4 partial word", d, 32'hFF);
      wr(32'h2000 + 32'h80 * 2, 32'hF0); rd(32'h2000 + 32'h80 * 2, d); chk("R4 even context", d, 0);
      rd(a_ena(0, 0), d); chk("R4 neighbour untouched", d, 0);
      wr(a_ena(1, 0), 0); wr(a_ena(1, 1), 0);
      rd(a_ena(1, 0), d); chk("R4 cleared", d, 0);
   endtask

   task automatic t_thresh();
      logic [31:0] d;
      wr(a_thr(2), 32'hF6); rd(a_thr(2), d); chk("R5 threshold low bits", d, 6);
      wr(a_thr(2), 0);
   endtask

   task automatic t_irq();
      wr(a_prio(10), 4); wr(a_ena(0, 0), 32'h400); wr(a_thr(0), 3);
      pulse(10);
      #1 chk("R6 irq above threshold", 32'(irq_o), 32'h1);
      wr(a_thr(0), 4); @(negedge clk);
      chk("R6 equal to threshold", 32'(irq_o), 32'h0);
      wr(a_thr(0), 0); wr(a_prio(10), 0); @(negedge clk);
      chk("R6 priority zero", 32'(irq_o), 32'h0);
      wr(a_prio(10), 4); wr(a_thr(0), 3); @(negedge clk);
      chk("R6 restored", 32'(irq_o), 32'h1);
   endtask

   task automatic t_claim();
      logic [31:0] d;
      wr(a_prio(12), 6); wr(a_prio(20), 6); wr(a_prio(14), 2);
      wr(a_ena(3, 0), (32'h1 << 12) | (32'h1 << 14) | (32'h1 << 20) | (32'h1 << 3));
      @(negedge clk); src_i[12] = 1'b1; src_i[14] = 1'b1; src_i[20] = 1'b1;
      @(negedge clk); src_i = '0;
      #1 chk("R6 context 7 raised", 32'(irq_o[3]), 32'h1);
      rd(a_clm(3), d); chk("R7 tie lowest id", d, 12);
      rd(a_clm(3), d); chk("R7 next tie", d, 20);
      rd(a_clm(3), d); chk("R7 lower priority", d, 14);
      rd(a_clm(3), d); chk("R7 none left", d, 0);
      chk("R8 irq drops", 32'(irq_o[3]), 32'h0);
      rd(a_pend(0), d); chk("R8 pending cleared", d & 32'h0010_5000, 0);
      @(negedge clk); src_i[12] = 1'b1;
      repeat (3) @(posedge clk);
      rd(a_pend(0), d); chk("R8 no relatch while claimed", d & 32'h1000, 0);
      wr(a_clm(3), 12);
      repeat (2) @(posedge clk);
      rd(a_pend(0), d); chk("R9 relatch after complete", d & 32'h1000, 32'h1000);
      @(negedge clk); src_i[12] = 1'b0;
      rd(a_clm(3), d); chk("R9 claim again", d, 12);
      wr(a_clm(3), 12); wr(a_clm(3), 20); wr(a_clm(3), 14);
   endtask

   task automatic t_complete_ignored();
      logic [31:0] d;
      rd(a_clm(0), d); chk("R7 context 1 claim", d, 10);
      @(negedge clk); src_i[10] = 1'b1;
      wr(a_clm(3), 10);
      repeat (2) @(posedge clk);
      rd(a_pend(0), d); chk("R9 complete where disabled", d & 32'h400, 0);
      wr(a_clm(0), 11);
      repeat (2) @(posedge clk);
      rd(a_pend(0), d); chk("R9 complete wrong id", d & 32'h400, 0);
      wr(a_clm(0), 10);
      repeat (2) @(posedge clk);
      rd(a_pend(0), d); chk("R9 matching complete", d & 32'h400, 32'h400);
      @(negedge clk); src_i[10] = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(32'h30_0000, 32'hFFFF_FFFF); rd(32'h30_0000, d); chk("R10 hole reads zero", d, 0);
      wr(32'h15, 7); rd(a_prio(5), d); chk("R10 misaligned write ignored", d, 5);
      rd(32'h15, d); chk("R10 misaligned read", d, 0);
      rd(32'h20_2000, d); chk("R10 even context reg", d, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_prio();
      t_pending();
      t_enable();
      t_thresh();
      t_irq();
      t_claim();
      t_complete_ignored();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule